// File: doc/BRIEF.md
# Select-Decoded Clock Output Divider

This block takes a fast source clock and produces a slower copy of it, divided by a ratio picked with a 3-bit select code. The result leaves the block on four identical differential-style pairs. Each pair has a true leg and a complement leg. Either a synthesized clock or an external test clock can be the source. A separate reference-select input is passed straight out, so the surrounding logic knows which reference feeds the synthesizer.

An asynchronous, active-high master reset parks every pair at once: true legs low, complement legs high. Its release is resynchronized to the source clock before the divider starts counting.

Each select code stands for a pair of values: an output divide ratio and the feedback multiplier that the synthesizer would use with it. The block reports both values for the code it is currently applying. A bench can therefore predict the output frequency from the reference frequency. A new code is applied only where one output period ends, so switching ratios never produces a short pulse.

Top module: `selclk_div`

## Requirements
- R1: The applied select code maps to (feedback multiplier, output ratio) as: 0 to (18, 3), 1 to (24, 4), 2 to (24, 8), 3 to (32, 1), 4 to (32, 2), 5 to (32, 4), 6 to (32, 8), 7 to (40, 8). `fb_ratio` and `out_ratio` report the pair for the applied code, and a code is applied at the period end that follows its appearance on `fsel`.
- R2: While `mr` is high, every bit of `out_p` is 0 and every bit of `out_n` is 1. This holds from the moment `mr` rises, without waiting for a clock edge.
- R3: With `mr` low, the period of `out_p` is the output ratio times the source-clock period.
- R4: A change of `fsel` takes effect only at the end of the current output period. The high phase in progress keeps its full length, and the reported ratios keep their old values until that period ends.
- R5: All four `out_p` bits are equal at all times, and `out_n` is the bitwise inverse of `out_p`.
- R6: For every ratio, including 3, `out_p` is high for half of its period. For ratio 3 this is 1.5 source periods.
- R7: At ratio 1, `out_p` is high exactly while the source clock is high.
- R8: For an even ratio N, once `mr` falls, `out_p` stays low and then first rises on the (N/2 + 2)-th source rising edge. Two of these edges go to reset resynchronization and N/2 to the first low half-period.
- R9: With `bypass_sel` high, the divider runs from `clk_test`. With `bypass_sel` low, it runs from `clk_synth`.
- R10: `ref_src` always equals `ref_sel`: 0 means crystal reference, 1 means test clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_synth | input | 1 | Synthesized fast clock, the normal divider source |
| clk_test | input | 1 | External test clock, used as the source in bypass |
| mr | input | 1 | Master reset, active high, asynchronous assertion |
| bypass_sel | input | 1 | 0: divide `clk_synth`; 1: divide `clk_test` |
| ref_sel | input | 1 | Reference choice: 0 crystal, 1 test clock |
| fsel | input | 3 | Frequency select code |
| out_p | output | 4 | True legs of the four output pairs |
| out_n | output | 4 | Complement legs of the four output pairs |
| ref_src | output | 1 | Reference-source choice passed through |
| fb_ratio | output | 6 | Feedback multiplier for the applied code |
| out_ratio | output | 4 | Output divide ratio for the applied code |

## Verification
The assertions check four things on every cycle of the source clock:
- The pairs are parked whenever reset is high.
- The applied ratio moves only on a period end or during reset.
- The ratio applied after a period end is the decoded value of the code that was present at that end.
- The outputs are still low in the cycle where the resynchronized reset drops.

Some properties can only be shown by the bench scenarios, because each needs times measured between output edges:
- the period and high time for each of the eight codes;
- the divide-by-3 half-cycle balance;
- the uncut high phase across a code change;
- the exact edge count to the first rising output;
- the effect of the bypass source.

// File: rtl/seldiv_pkg.sv
package seldiv_pkg;

    localparam int SEL_W = 3;
    localparam int FB_W  = 6;
    localparam int DIV_W = 4;

    typedef logic [SEL_W-1:0] sel_t;

    typedef struct packed {
        logic [FB_W-1:0]  fb;
        logic [DIV_W-1:0] div;
    } ratio_t;

    // Select code to (feedback multiplier, output ratio)
    function automatic ratio_t decode_sel(sel_t s);
        ratio_t r;
        case (s)
            3'd0:    r = '{fb: FB_W'(18), div: DIV_W'(3)};
            3'd1:    r = '{fb: FB_W'(24), div: DIV_W'(4)};
            3'd2:    r = '{fb: FB_W'(24), div: DIV_W'(8)};
            3'd3:    r = '{fb: FB_W'(32), div: DIV_W'(1)};
            3'd4:    r = '{fb: FB_W'(32), div: DIV_W'(2)};
            3'd5:    r = '{fb: FB_W'(32), div: DIV_W'(4)};
            3'd6:    r = '{fb: FB_W'(32), div: DIV_W'(8)};
            default: r = '{fb: FB_W'(40), div: DIV_W'(8)};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/seldiv_rst_sync.sv
// Reset release resynchronizer: asserts at once, releases after STAGES edges.
module seldiv_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic mr,
    output logic rst_s
);
    logic [STAGES-1:0] sh_q;

    always_ff @(posedge clk or posedge mr) begin
        if (mr) sh_q <= '1;
        else    sh_q <= {sh_q[STAGES-2:0], 1'b0};
    end

    assign rst_s = sh_q[STAGES-1];
endmodule

// File: rtl/seldiv_code_reg.sv
// Holds the applied select code; reloads only in reset or at a period end.
module seldiv_code_reg
    import seldiv_pkg::*;
(
    input  logic   clk,
    input  logic   rst_s,
    input  logic   wrap,
    input  sel_t   fsel,
    output ratio_t ratio
);
    sel_t code_q;

    always_ff @(posedge clk) begin
        if (rst_s || wrap) code_q <= fsel;
    end

    assign ratio = decode_sel(code_q);
endmodule

// File: rtl/seldiv_core.sv
// Ratio counter with a dual-edge extension for odd ratios and a
// pass-through path for ratio 1.
module seldiv_core
    import seldiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst_s,
    input  logic [DIV_W-1:0] n,
    output logic             wrap,
    output logic             div_clk
);
    logic [DIV_W-1:0] c_q, c_nx, hi_from;
    logic             a_q, b_q, d1_q;
    logic             is_one, is_odd;

    assign is_one  = (n == DIV_W'(1));
    assign is_odd  = n[0];
    assign wrap    = (c_q == n - DIV_W'(1));
    assign c_nx    = wrap ? '0 : c_q + DIV_W'(1);
    // The rising-edge phase starts at floor(n/2), one later for odd n.
    // The falling-edge flop then adds the missing half cycle.
    assign hi_from = (n >> 1) + DIV_W'(is_odd);

    always_ff @(posedge clk) begin
        if (rst_s) begin
            c_q <= '0;
            a_q <= 1'b0;
        end else begin
            c_q <= c_nx;
            a_q <= !is_one && (c_nx >= hi_from);
        end
    end

    always_ff @(negedge clk) begin
        if (rst_s) begin
            b_q  <= 1'b0;
            d1_q <= 1'b0;
        end else begin
            b_q  <= a_q & is_odd;
            d1_q <= is_one;
        end
    end

    assign div_clk = a_q | b_q | (clk & d1_q);
endmodule

// File: rtl/seldiv_fanout.sv
// Drives NPAIR matched true/complement pairs, parked while mr is high.
module seldiv_fanout #(
    parameter int NPAIR = 4
) (
    input  logic             div_clk,
    input  logic             mr,
    output logic [NPAIR-1:0] out_p,
    output logic [NPAIR-1:0] out_n
);
    for (genvar i = 0; i < NPAIR; i++) begin : g_pair
        assign out_p[i] = div_clk & ~mr;
        assign out_n[i] = ~out_p[i];
    end
endmodule

// File: rtl/selclk_div.sv
module selclk_div
    import seldiv_pkg::*;
#(
    parameter int NPAIR     = 4,
    parameter int RS_STAGES = 2
) (
    input  logic             clk_synth,
    input  logic             clk_test,
    input  logic             mr,
    input  logic             bypass_sel,
    input  logic             ref_sel,
    input  logic [SEL_W-1:0] fsel,
    output logic [NPAIR-1:0] out_p,
    output logic [NPAIR-1:0] out_n,
    output logic             ref_src,
    output logic [FB_W-1:0]  fb_ratio,
    output logic [DIV_W-1:0] out_ratio
);
    logic   src_clk;
    logic   rst_s;
    logic   wrap;
    logic   div_clk;
    ratio_t ratio;

    assign src_clk   = bypass_sel ? clk_test : clk_synth;
    assign ref_src   = ref_sel;
    assign fb_ratio  = ratio.fb;
    assign out_ratio = ratio.div;

    seldiv_rst_sync #(.STAGES(RS_STAGES)) u_rst (
        .clk   (src_clk),
        .mr    (mr),
        .rst_s (rst_s)
    );

    seldiv_code_reg u_code (
        .clk   (src_clk),
        .rst_s (rst_s),
        .wrap  (wrap),
        .fsel  (fsel),
        .ratio (ratio)
    );

    seldiv_core u_core (
        .clk     (src_clk),
        .rst_s   (rst_s),
        .n       (ratio.div),
        .wrap    (wrap),
        .div_clk (div_clk)
    );

    seldiv_fanout #(.NPAIR(NPAIR)) u_fan (
        .div_clk (div_clk),
        .mr      (mr),
        .out_p   (out_p),
        .out_n   (out_n)
    );
endmodule

// File: rtl/selclk_div_chk.sv
module selclk_div_chk
    import seldiv_pkg::*;
#(
    parameter int NPAIR = 4
) (
    input logic             src_clk,
    input logic             mr,
    input logic             rst_s,
    input logic             wrap,
    input logic [SEL_W-1:0] fsel,
    input ratio_t           ratio,
    input logic [NPAIR-1:0] out_p,
    input logic [NPAIR-1:0] out_n
);
    // R2: reset parks every pair
    a_r2_reset_park: assert property (@(negedge src_clk)
        mr |-> (out_p == '0 && out_n == '1));

    // R8: outputs still low when the resynchronized reset drops
    a_r8_first_low: assert property (@(posedge src_clk)
        $fell(rst_s) |-> (out_p == '0));

    // R4: applied ratio moves only after a period end or reset
    a_r4_ratio_hold: assert property (@(posedge src_clk) disable iff (rst_s)
        (!$past(wrap) && !$past(rst_s)) |-> $stable(ratio));

    // R1: ratio applied at a period end is the decode of the code seen there
    a_r1_code_pairs: assert property (@(posedge src_clk) disable iff (rst_s)
        wrap |=> (ratio == decode_sel($past(fsel))));
endmodule

bind selclk_div selclk_div_chk #(.NPAIR(NPAIR)) u_chk (
    .src_clk (src_clk),
    .mr      (mr),
    .rst_s   (rst_s),
    .wrap    (wrap),
    .fsel    (fsel),
    .ratio   (ratio),
    .out_p   (out_p),
    .out_n   (out_n)
);

// File: tb/selclk_div_tb.sv
`timescale 1ns/100ps
module selclk_div_tb;
    logic       clk_synth = 1'b0;
    logic       clk_test  = 1'b0;
    logic       mr        = 1'b0;
    logic       bypass_sel = 1'b0;
    logic       ref_sel   = 1'b0;
    logic [2:0] fsel      = 3'b101;
    logic [3:0] out_p, out_n;
    logic       ref_src;
    logic [5:0] fb_ratio;
    logic [3:0] out_ratio;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // {code, feedback multiplier, output ratio}
    localparam logic [12:0] VEC [8] = '{
        {3'd0, 6'd18, 4'd3}, {3'd1, 6'd24, 4'd4},
        {3'd2, 6'd24, 4'd8}, {3'd3, 6'd32, 4'd1},
        {3'd4, 6'd32, 4'd2}, {3'd5, 6'd32, 4'd4},
        {3'd6, 6'd32, 4'd8}, {3'd7, 6'd40, 4'd8}
    };

    always #5 clk_synth = ~clk_synth;
    initial begin
        #3;
        forever #8 clk_test = ~clk_test;
    end

    selclk_div u_dut (
        .clk_synth  (clk_synth),
        .clk_test   (clk_test),
        .mr         (mr),
        .bypass_sel (bypass_sel),
        .ref_sel    (ref_sel),
        .fsel       (fsel),
        .out_p      (out_p),
        .out_n      (out_n),
        .ref_src    (ref_src),
        .fb_ratio   (fb_ratio),
        .out_ratio  (out_ratio)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic measure(output int hi, output int per);
        realtime t0, t1, t2;
        @(posedge out_p[0]); t0 = $realtime;
        @(negedge out_p[0]); t1 = $realtime;
        @(posedge out_p[0]); t2 = $realtime;
        hi  = int'(t1 - t0);
        per = int'(t2 - t0);
    endtask

    initial begin
        int hi, per, n;
        bit rose;
        realtime ts;

        #1 mr = 1'b1;
        repeat (4) @(posedge clk_synth);
        #1;
        chk(out_p == 4'h0, "R2 reset true legs", int'(out_p), 0);
        chk(out_n == 4'hF, "R2 reset complement legs", int'(out_n), 15);

        // R8: ratio 4, first rise on the 4th source rising edge
        @(negedge clk_synth);
        mr = 1'b0;
        n = 0;
        rose = 1'b0;
        for (int k = 0; k < 20 && !rose; k++) begin
            @(posedge clk_synth);
            #1;
            n++;
            if (out_p[0]) rose = 1'b1;
        end
        chk(n == 4, "R8 first rising edge count", n, 4);

        // Table walk: R1, R3, R5, R6
        for (int i = 0; i < 8; i++) begin
            @(posedge clk_synth);
            #1 fsel = VEC[i][12:10];
            repeat (20) @(posedge clk_synth);
            #1;
            chk(fb_ratio == VEC[i][9:4], "R1 feedback multiplier", int'(fb_ratio), int'(VEC[i][9:4]));
            chk(out_ratio == VEC[i][3:0], "R1 output ratio", int'(out_ratio), int'(VEC[i][3:0]));
            measure(hi, per);
            chk(per == 10 * int'(VEC[i][3:0]), "R3 output period", per, 10 * int'(VEC[i][3:0]));
            chk(hi == 5 * int'(VEC[i][3:0]), "R6 high time", hi, 5 * int'(VEC[i][3:0]));
            #2;
            chk(out_n == ~out_p && (out_p == 4'h0 || out_p == 4'hF),
                "R5 matched pairs", int'(out_p), int'(~out_n));
        end

        // R7: ratio 1 follows the source
        @(posedge clk_synth);
        #1 fsel = 3'b011;
        repeat (20) @(posedge clk_synth);
        #2;
        chk(out_p == 4'hF, "R7 high with source", int'(out_p), 15);
        #5;
        chk(out_p == 4'h0, "R7 low with source", int'(out_p), 0);

        // R4: change code in mid high phase of ratio 8
        @(posedge clk_synth);
        #1 fsel = 3'b111;
        repeat (20) @(posedge clk_synth);
        @(posedge out_p[0]);
        ts = $realtime;
        #1 fsel = 3'b011;
        chk(fb_ratio == 6'd40, "R4 old multiplier held", int'(fb_ratio), 40);
        @(negedge out_p[0]);
        hi = int'($realtime - ts);
        chk(hi == 40, "R4 high phase not cut", hi, 40);
        repeat (2) @(posedge clk_synth);
        #1;
        chk(fb_ratio == 6'd32 && out_ratio == 4'd1, "R4 new code applied",
            int'(out_ratio), 1);

        // R2 mid-run: park at once
        @(posedge clk_synth);
        #2 mr = 1'b1;
        #1;
        chk(out_p == 4'h0 && out_n == 4'hF, "R2 immediate park", int'(out_p), 0);
        repeat (5) @(posedge clk_synth);
        #2;
        chk(out_p == 4'h0 && out_n == 4'hF, "R2 park held", int'(out_p), 0);

        // R9: bypass to the 16 ns test clock, ratio 2
        bypass_sel = 1'b1;
        fsel = 3'b100;
        repeat (4) @(posedge clk_test);
        #1 mr = 1'b0;
        repeat (20) @(posedge clk_test);
        measure(hi, per);
        chk(per == 32, "R9 bypass period", per, 32);
        chk(hi == 16, "R9 bypass high time", hi, 16);

        // R10: reference choice passes through
        ref_sel = 1'b1;
        #1;
        chk(ref_src == 1'b1, "R10 test reference", int'(ref_src), 1);
        ref_sel = 1'b0;
        #1;
        chk(ref_src == 1'b0, "R10 crystal reference", int'(ref_src), 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule